// File: doc/BRIEF.md
# Queued SPI master sequencer

This block is an SPI master that works through a stored queue of transfers with no help from the CPU. The CPU fills a small shared memory with, for each queue slot, a command byte and a transmit word. It then sets a start and an end slot and sets the run bit. The sequencer takes each slot in turn and drives its chip-select pattern. It shifts the word out MSB first with a clock that idles low, sampling on the rising edge and shifting on the falling edge. The received word goes into the receive slot with the same index. When the end slot is done, the queue either stops or, with wraparound set, starts again from the start slot.

Progress is reported through a status word. It holds a finished flag, a mode-fault flag, a halt-acknowledge flag and a completed-slot pointer. A halt request or an enabled freeze input parks the queue between transfers. A low level on the slave-select input while the queue is enabled is treated as another master on the bus, and the block drops off the bus at once. Each flag can raise the single interrupt line.

Top module: `qspi_seq`

## Requirements
- R1: Address map: `cpu_addr_i` top two bits choose the region (0 receive, 1 transmit, 2 command, 3 registers) and its low PW bits give the slot or register index. Registers are 0 control (bit 0 run, 1 wrap, 2 halt, 3 freeze enable, 4 finish irq enable, 5 fault irq enable, 6 halt irq enable), 1 pointers (start slot in bits PW-1:0, end slot from bit 8), and 2 status (bit 0 finished, 1 mode fault, 2 halt acknowledged, completed slot from bit 8). After reset, control and status read 0, `cs_no` is all ones, and `sck_o` and `irq_o` are low.
- R2: Slots run in index order from the start slot to the end slot, counting modulo the queue depth. Each slot makes exactly one transfer, MSB first on `mosi_o`, with `sck_o` idling low and `miso_i` sampled on each rising edge.
- R3: Command bits 3:0 are driven on `cs_no` for the whole transfer. Command bit 6 set selects 16 bits per transfer and clear selects 8, taken from the low byte of the transmit word. The received bits are stored in the same-index receive slot, zero-extended for 8-bit transfers.
- R4: With command bit 7 set, `cs_no` stays asserted from that transfer into the next slot. With it clear, `cs_no` returns to all ones after the transfer. `sck_o` is low whenever `cs_no` is all ones.
- R5: The finished flag is set when the end slot completes. Without wrap the queue then stops and the run bit reads 0.
- R6: With wrap set, execution continues from the start slot after the end slot, and the finished flag is set again on every pass.
- R7: The completed-slot pointer takes the index of each slot as it completes. It keeps its previous value until the first slot of a new queue completes.
- R8: A set halt bit stops the queue only at a transfer boundary. The running transfer finishes, the halt-acknowledge flag is set, and no clock pulses appear until halt is cleared, after which the next slot runs.
- R9: `freeze_i` high acts as a halt request when freeze enable is set and has no effect otherwise.
- R10: `ss_ni` low while the run bit is set sets the mode-fault flag. On the next edge the run bit is cleared, `cs_no` goes to all ones and `sck_o` goes low. `ss_ni` low with run clear has no effect.
- R11: A status flag is cleared only by writing 0 to its bit after the status word was read with that bit at 1. A write of 0 without a prior read leaves it set.
- R12: `irq_o` is high exactly when some status flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe (arms flag clearing) |
| cpu_addr_i | input | PW+2 | CPU word address |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | CPU read data, combinational from address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 4 | Chip selects, active low |
| ss_ni | input | 1 | Slave-select sense, low means bus contention |
| freeze_i | input | 1 | Debug freeze request |
| irq_o | output | 1 | Interrupt request |

## Verification
The checks assume that `ss_ni`, `freeze_i` and `miso_i` are synchronous to `clk_i`. They also assume the CPU leaves the pointer word, the command and transmit slots alone while the queue runs, and writes the control word only to start, halt, resume or stop it. The stimulus drives every input on the falling clock edge and rewrites slots and pointers only after the finished flag shows the queue has stopped. Halt, freeze and fault are always applied in the middle of a transfer, located by counting serial clock edges.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  localparam int CS_W    = 4;
  localparam int DATA_W  = 16;
  localparam int NFLAG   = 3;

  typedef enum logic [1:0] {
    RG_RX  = 2'd0,
    RG_TX  = 2'd1,
    RG_CMD = 2'd2,
    RG_CSR = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_WAIT   = 2'd2,
    SQ_HALT   = 2'd3
  } seq_state_e;

  // control word bits
  localparam int CT_RUN   = 0;
  localparam int CT_WRAP  = 1;
  localparam int CT_HALT  = 2;
  localparam int CT_FRZEN = 3;
  localparam int CT_IE0   = 4;
  localparam int CT_W     = 7;

  // status flag bits, ie bit = CT_IE0 + flag bit
  localparam int FL_FIN   = 0;
  localparam int FL_FAULT = 1;
  localparam int FL_HACK  = 2;

  localparam int PTR_HI_LSB = 8;
endpackage

// File: rtl/qspi_queue_ram.sv
module qspi_queue_ram
  import qspi_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              cpu_we_i,
  input  region_e           cpu_region_i,
  input  logic [PW-1:0]     cpu_idx_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rx_o,
  output logic [DATA_W-1:0] cpu_tx_o,
  output logic [7:0]        cpu_cmd_o,
  input  logic [PW-1:0]     seq_idx_i,
  output logic [CS_W-1:0]   seq_cs_o,
  output logic              seq_cont_o,
  output logic              seq_wide_o,
  output logic [DATA_W-1:0] seq_tx_o,
  input  logic              seq_rx_we_i,
  input  logic [DATA_W-1:0] seq_rx_i
);
  logic [DATA_W-1:0] rx_mem  [DEPTH];
  logic [DATA_W-1:0] tx_mem  [DEPTH];
  logic [7:0]        cmd_mem [DEPTH];
  logic [7:0]        cmd_rd;

  always_ff @(posedge clk_i) begin
    if (cpu_we_i && cpu_region_i == RG_TX)  tx_mem[cpu_idx_i]  <= cpu_wdata_i;
    if (cpu_we_i && cpu_region_i == RG_CMD) cmd_mem[cpu_idx_i] <= cpu_wdata_i[7:0];
    if (seq_rx_we_i)                        rx_mem[seq_idx_i]  <= seq_rx_i;
  end

  assign cpu_rx_o  = rx_mem[cpu_idx_i];
  assign cpu_tx_o  = tx_mem[cpu_idx_i];
  assign cpu_cmd_o = cmd_mem[cpu_idx_i];

  assign cmd_rd     = cmd_mem[seq_idx_i];
  assign seq_cs_o   = cmd_rd[CS_W-1:0];
  assign seq_wide_o = cmd_rd[6];
  assign seq_cont_o = cmd_rd[7];
  assign seq_tx_o   = tx_mem[seq_idx_i];
endmodule

// File: rtl/qspi_shift_eng.sv
module qspi_shift_eng
  import qspi_seq_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int DW = (CLK_DIV <= 1) ? 1 : $clog2(CLK_DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic              busy_q, done_q, sck_q;
  logic [DATA_W-1:0] tsr_q, rsr_q;
  logic [4:0]        left_q;
  logic [DW-1:0]     div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      tsr_q  <= '0;
      rsr_q  <= '0;
      left_q <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        div_q  <= '0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        div_q  <= '0;
        rsr_q  <= '0;
        tsr_q  <= wide_i ? tx_i : {tx_i[7:0], 8'h00};
        left_q <= wide_i ? 5'd16 : 5'd8;
      end else if (busy_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rsr_q <= {rsr_q[DATA_W-2:0], miso_i};
          end else begin
            sck_q  <= 1'b0;
            tsr_q  <= {tsr_q[DATA_W-2:0], 1'b0};
            left_q <= left_q - 5'd1;
            if (left_q == 5'd1) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rsr_q;
  assign sck_o  = sck_q;
  assign mosi_o = tsr_q[DATA_W-1];
endmodule

// File: rtl/qspi_sequencer.sv
module qspi_sequencer
  import qspi_seq_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            wrap_i,
  input  logic            halt_req_i,
  input  logic            fault_i,
  input  logic [PW-1:0]   start_ptr_i,
  input  logic [PW-1:0]   end_ptr_i,
  input  logic [CS_W-1:0] cmd_cs_i,
  input  logic            cmd_cont_i,
  input  logic            sh_done_i,
  output logic [PW-1:0]   ptr_o,
  output logic [PW-1:0]   cptqp_o,
  output logic            sh_start_o,
  output logic            sh_abort_o,
  output logic            rx_we_o,
  output logic            finish_o,
  output logic            stop_o,
  output logic            halt_ack_o,
  output logic [CS_W-1:0] cs_no,
  output seq_state_e      state_o
);
  seq_state_e      state_q, state_d;
  logic [PW-1:0]   ptr_q, ptr_d, cpt_q, cpt_d;
  logic [CS_W-1:0] cs_q, cs_d;
  logic            cont_q, cont_d;
  logic            last;

  assign last = (ptr_q == end_ptr_i);

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    cpt_d      = cpt_q;
    cs_d       = cs_q;
    cont_d     = cont_q;
    sh_start_o = 1'b0;
    sh_abort_o = 1'b0;
    rx_we_o    = 1'b0;
    finish_o   = 1'b0;
    stop_o     = 1'b0;
    halt_ack_o = 1'b0;
    if (fault_i) begin
      state_d    = SQ_IDLE;
      cs_d       = '1;
      sh_abort_o = 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (run_i) begin
            ptr_d   = start_ptr_i;
            state_d = SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: begin
          sh_start_o = 1'b1;
          cs_d       = cmd_cs_i;
          cont_d     = cmd_cont_i;
          state_d    = SQ_WAIT;
        end
        SQ_WAIT: begin
          if (sh_done_i) begin
            rx_we_o  = 1'b1;
            cpt_d    = ptr_q;
            finish_o = last;
            ptr_d    = last ? start_ptr_i : ptr_q + 1'b1;
            if ((last && !wrap_i) || !run_i) begin
              stop_o  = last && !wrap_i;
              state_d = SQ_IDLE;
              cs_d    = '1;
            end else if (halt_req_i) begin
              halt_ack_o = 1'b1;
              state_d    = SQ_HALT;
              cs_d       = '1;
            end else begin
              state_d = SQ_LAUNCH;
              if (!cont_q) cs_d = '1;
            end
          end
        end
        SQ_HALT: begin
          if (!run_i)           state_d = SQ_IDLE;
          else if (!halt_req_i) state_d = SQ_LAUNCH;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      cpt_q   <= '0;
      cs_q    <= '1;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      cpt_q   <= cpt_d;
      cs_q    <= cs_d;
      cont_q  <= cont_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign cptqp_o = cpt_q;
  assign cs_no   = cs_q;
  assign state_o = state_q;
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_seq_pkg::*;
#(
  parameter int QDEPTH  = 32,
  parameter int CLK_DIV = 2,
  localparam int PW     = $clog2(QDEPTH),
  localparam int AW     = PW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_W-1:0]   cs_no,
  input  logic              ss_ni,
  input  logic              freeze_i,
  output logic              irq_o
);
  region_e           region;
  logic [PW-1:0]     idx;
  logic              csr_we, stat_we, stat_re;
  logic [CT_W-1:0]   ctrl_q;
  logic [PW-1:0]     start_q, end_q;
  logic [NFLAG-1:0]  flag_q, flag_set, flag_ie;
  logic              run_en, halt_req, fault_det;
  logic              fin_q, fault_q, hack_q;

  logic [PW-1:0]     seq_ptr, cptqp;
  logic [CS_W-1:0]   cmd_cs;
  logic              cmd_cont, cmd_wide;
  logic [DATA_W-1:0] seq_tx, sh_rx, cpu_rx, cpu_tx;
  logic [7:0]        cpu_cmd;
  logic              sh_start, sh_abort, sh_done, sh_busy;
  logic              rx_we, seq_finish, seq_stop, seq_hack;
  seq_state_e        seq_state;

  assign region  = region_e'(cpu_addr_i[AW-1 -: 2]);
  assign idx     = cpu_addr_i[PW-1:0];
  assign csr_we  = cpu_we_i && region == RG_CSR;
  assign stat_we = csr_we && idx == PW'(2);
  assign stat_re = cpu_re_i && region == RG_CSR && idx == PW'(2);

  assign run_en    = ctrl_q[CT_RUN];
  assign halt_req  = ctrl_q[CT_HALT] | (ctrl_q[CT_FRZEN] & freeze_i);
  assign fault_det = run_en & ~ss_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (csr_we && idx == PW'(0)) ctrl_q <= cpu_wdata_i[CT_W-1:0];
      if (csr_we && idx == PW'(1)) begin
        start_q <= cpu_wdata_i[PW-1:0];
        end_q   <= cpu_wdata_i[PTR_HI_LSB +: PW];
      end
      if (seq_stop || fault_det) ctrl_q[CT_RUN] <= 1'b0;
    end
  end

  assign flag_set = {seq_hack, fault_det, seq_finish};
  assign flag_ie  = ctrl_q[CT_IE0 +: NFLAG];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q, arm_q, clr;
    assign clr = stat_we && !cpu_wdata_i[g] && arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q   <= 1'b0;
        arm_q <= 1'b0;
      end else begin
        if (flag_set[g])  f_q <= 1'b1;
        else if (clr)     f_q <= 1'b0;
        if (clr && !flag_set[g])  arm_q <= 1'b0;
        else if (stat_re && f_q)  arm_q <= 1'b1;
      end
    end
    assign flag_q[g] = f_q;
  end

  assign fin_q   = flag_q[FL_FIN];
  assign fault_q = flag_q[FL_FAULT];
  assign hack_q  = flag_q[FL_HACK];
  assign irq_o   = |(flag_q & flag_ie);

  always_comb begin
    cpu_rdata_o = '0;
    unique case (region)
      RG_RX:  cpu_rdata_o = cpu_rx;
      RG_TX:  cpu_rdata_o = cpu_tx;
      RG_CMD: cpu_rdata_o = {8'h00, cpu_cmd};
      RG_CSR: begin
        if (idx == PW'(0)) cpu_rdata_o[CT_W-1:0] = ctrl_q;
        if (idx == PW'(1)) begin
          cpu_rdata_o[PW-1:0]            = start_q;
          cpu_rdata_o[PTR_HI_LSB +: PW]  = end_q;
        end
        if (idx == PW'(2)) begin
          cpu_rdata_o[FL_FIN]            = fin_q;
          cpu_rdata_o[FL_FAULT]          = fault_q;
          cpu_rdata_o[FL_HACK]           = hack_q;
          cpu_rdata_o[PTR_HI_LSB +: PW]  = cptqp;
        end
      end
      default: cpu_rdata_o = '0;
    endcase
  end

  qspi_queue_ram #(.DEPTH(QDEPTH), .PW(PW)) u_ram (
    .clk_i        (clk_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_region_i (region),
    .cpu_idx_i    (idx),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_rx_o     (cpu_rx),
    .cpu_tx_o     (cpu_tx),
    .cpu_cmd_o    (cpu_cmd),
    .seq_idx_i    (seq_ptr),
    .seq_cs_o     (cmd_cs),
    .seq_cont_o   (cmd_cont),
    .seq_wide_o   (cmd_wide),
    .seq_tx_o     (seq_tx),
    .seq_rx_we_i  (rx_we),
    .seq_rx_i     (sh_rx)
  );

  qspi_shift_eng #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .abort_i (sh_abort),
    .wide_i  (cmd_wide),
    .tx_i    (seq_tx),
    .miso_i  (miso_i),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );

  qspi_sequencer #(.PW(PW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_en),
    .wrap_i      (ctrl_q[CT_WRAP]),
    .halt_req_i  (halt_req),
    .fault_i     (fault_det),
    .start_ptr_i (start_q),
    .end_ptr_i   (end_q),
    .cmd_cs_i    (cmd_cs),
    .cmd_cont_i  (cmd_cont),
    .sh_done_i   (sh_done),
    .ptr_o       (seq_ptr),
    .cptqp_o     (cptqp),
    .sh_start_o  (sh_start),
    .sh_abort_o  (sh_abort),
    .rx_we_o     (rx_we),
    .finish_o    (seq_finish),
    .stop_o      (seq_stop),
    .halt_ack_o  (seq_hack),
    .cs_no       (cs_no),
    .state_o     (seq_state)
  );
endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk
  import qspi_seq_pkg::*;
#(
  parameter int PW = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CS_W-1:0] cs_no,
  input logic            sck_o,
  input logic            run_en,
  input logic            fin_q,
  input logic            fault_q,
  input logic            hack_q,
  input logic            sh_busy,
  input logic [PW-1:0]   cptqp,
  input logic [PW-1:0]   end_q,
  input seq_state_e      seq_state
);
  AST_FAULT_DROPS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> (cs_no == '1 && !sck_o && !run_en)); // R10

  AST_FINISH_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin_q) |-> (cptqp == end_q)); // R5

  AST_HALT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hack_q) |-> (!sh_busy && cs_no == '1)); // R8

  AST_DESELECT_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no == '1) |-> !sck_o); // R4

  AST_CPT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_state == SQ_IDLE) |=> $stable(cptqp)); // R7
endmodule

bind qspi_seq qspi_seq_chk #(.PW(PW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_no     (cs_no),
  .sck_o     (sck_o),
  .run_en    (run_en),
  .fin_q     (fin_q),
  .fault_q   (fault_q),
  .hack_q    (hack_q),
  .sh_busy   (sh_busy),
  .cptqp     (cptqp),
  .end_q     (end_q),
  .seq_state (seq_state)
);

// File: tb/qspi_seq_test.sv
module qspi_seq_test;
  localparam int QD = 8;
  localparam int PW = 3;
  localparam int AW = PW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_we = 1'b0, cpu_re = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0, cpu_rdata;
  logic          sck, mosi, miso;
  logic [3:0]    cs_n;
  logic          ss_n = 1'b1, freeze = 1'b0, irq;
  logic          inv = 1'b1;

  int checks = 0, fails = 0;
  int rises = 0, rels = 0;
  logic [15:0] mosi_word = '0;
  logic [3:0]  cs_at_rise = '1;
  logic [3:0]  cs_prev = '1;
  logic [7:0]  blog [64];
  bit          done_run = 1'b0;

  always #4 clk = ~clk;
  assign miso = inv ? ~mosi : mosi;

  qspi_seq #(.QDEPTH(QD), .CLK_DIV(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(cpu_we), .cpu_re_i(cpu_re),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n),
    .ss_ni(ss_n), .freeze_i(freeze), .irq_o(irq)
  );

  always @(posedge sck) begin
    mosi_word = {mosi_word[14:0], mosi};
    if (rises[2:0] == 3'd7 && rises < 512) blog[rises >> 3] = mosi_word[7:0];
    rises = rises + 1;
    cs_at_rise = cs_n;
  end

  always @(posedge clk) begin
    if (cs_prev != 4'hF && cs_n == 4'hF) rels = rels + 1;
    cs_prev <= cs_n;
  end

  function automatic logic [AW-1:0] ad(input logic [1:0] r, input int i);
    return {r, i[PW-1:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  task automatic wait_flag(input int b);
    logic [15:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(ad(2'd3, 2), d);
      if (d[b]) break;
    end
  endtask

  task automatic wait_rises(input int n);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (rises >= n) break;
    end
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic clear_flags();
    logic [15:0] d;
    rd(ad(2'd3, 2), d);
    wr(ad(2'd3, 2), 16'h0000);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8 - 100);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  txv;
    int          n, stop_r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ad(2'd3, 0), d);  chk("R1 ctrl", d, 16'h0);
    rd(ad(2'd3, 2), d);  chk("R1 status", d, 16'h0);
    chk("R1 cs", cs_n, 4'hF);
    chk("R1 sck", sck, 1'b0);
    chk("R1 irq", irq, 1'b0);

    // R2 R3 R5 R7 sweep over all start/end pairs, 8-bit, inverted loopback
    inv = 1'b1;
    for (int s = 0; s < QD; s++) begin
      for (int e = 0; e < QD; e++) begin
        for (int i = 0; i < QD; i++) begin
          wr(ad(2'd2, i), 16'(4'hF ^ (4'h1 << (i % 4))));
          wr(ad(2'd1, i), 16'((i * 37 + s * 5 + e) & 8'hFF));
        end
        wr(ad(2'd3, 1), 16'((e << 8) | s));
        clear_flags();
        @(negedge clk); rises = 0;
        wr(ad(2'd3, 0), 16'h0001);
        wait_flag(0);
        n = ((e - s + QD) % QD) + 1;
        rd(ad(2'd3, 2), d);
        chk("R7 cptqp sweep", d[8 +: PW], e[PW-1:0]);
        chk("R2 bit count", rises, n * 8);
        rd(ad(2'd3, 0), d);
        chk("R5 run cleared", d[0], 1'b0);
        for (int k = 0; k < n; k++) begin
          int j;
          j = (s + k) % QD;
          txv = 8'((j * 37 + s * 5 + e) & 8'hFF);
          chk("R2 order", blog[k], txv);
          rd(ad(2'd0, j), d);
          chk("R3 rx 8-bit", d, {8'h00, ~txv});
        end
      end
    end

    // R3 16-bit transfer with chip-select code
    wr(ad(2'd2, 0), 16'h004A);
    wr(ad(2'd1, 0), 16'hB2C5);
    wr(ad(2'd3, 1), 16'h0000);
    clear_flags();
    @(negedge clk); rises = 0;
    wr(ad(2'd3, 0), 16'h0001);
    wait_flag(0);
    chk("R3 16 bits", rises, 16);
    chk("R2 msb first", mosi_word, 16'hB2C5);
    chk("R3 cs code", cs_at_rise, 4'hA);
    rd(ad(2'd0, 0), d);
    chk("R3 rx 16-bit", d, 16'h4D3A);
    chk("R4 cs released", cs_n, 4'hF);

    // R4 continue bit
    for (int c = 0; c < 2; c++) begin
      wr(ad(2'd2, 0), c ? 16'h0086 : 16'h0006);
      wr(ad(2'd2, 1), 16'h0006);
      wr(ad(2'd3, 1), 16'h0100);
      clear_flags();
      @(negedge clk); rels = 0;
      wr(ad(2'd3, 0), 16'h0001);
      wait_flag(0);
      repeat (4) @(negedge clk);
      chk("R4 release count", rels, c ? 1 : 2);
    end

    // R6 wraparound with finish irq (R12)
    for (int i = 0; i < QD; i++) begin
      wr(ad(2'd2, i), 16'h0047);
      wr(ad(2'd1, i), 16'(i * 16'h1111));
    end
    wr(ad(2'd3, 1), 16'h0302);
    clear_flags();
    wr(ad(2'd3, 0), 16'h0013);
    wait_flag(0);
    chk("R12 finish irq", irq, 1'b1);
    wr(ad(2'd3, 2), 16'h0000);
    rd(ad(2'd3, 2), d);
    chk("R11 finish cleared", d[0], 1'b0);
    wait_flag(0);
    rd(ad(2'd3, 2), d);
    chk("R6 finish again", d[0], 1'b1);
    chk("R6 cptqp", d[8 +: PW], 3'd3);
    rd(ad(2'd3, 0), d);
    chk("R6 still running", d[0], 1'b1);
    wr(ad(2'd3, 0), 16'h0000);
    repeat (100) @(negedge clk);
    stop_r = rises;
    repeat (100) @(negedge clk);
    chk("R6 stopped", rises, stop_r);
    chk("R4 stopped cs", cs_n, 4'hF);

    // R8 halt at boundary with halt irq (R12)
    for (int i = 0; i < QD; i++) wr(ad(2'd2, i), 16'h0007);
    wr(ad(2'd3, 1), 16'h0500);
    clear_flags();
    @(negedge clk); rises = 0;
    wr(ad(2'd3, 0), 16'h0041);
    wait_rises(4);
    wr(ad(2'd3, 0), 16'h0045);
    wait_irq();
    chk("R12 halt irq", irq, 1'b1);
    rd(ad(2'd3, 2), d);
    chk("R8 halt ack", d[2], 1'b1);
    chk("R8 cptqp at halt", d[8 +: PW], 3'd0);
    chk("R8 first done", rises, 8);
    repeat (200) @(negedge clk);
    chk("R8 no clocks", rises, 8);
    chk("R8 cs idle", cs_n, 4'hF);
    wr(ad(2'd3, 2), 16'h0000);
    wr(ad(2'd3, 0), 16'h0001);
    wait_flag(0);
    rd(ad(2'd3, 2), d);
    chk("R8 resumed cptqp", d[8 +: PW], 3'd5);
    chk("R8 total bits", rises, 48);

    // R7 pointer kept until first completion of new queue
    for (int i = 0; i < QD; i++) wr(ad(2'd2, i), 16'h0047);
    wr(ad(2'd3, 1), 16'h0301);
    clear_flags();
    @(negedge clk); rises = 0;
    wr(ad(2'd3, 0), 16'h0001);
    wait_rises(2);
    rd(ad(2'd3, 2), d);
    chk("R7 held value", d[8 +: PW], 3'd5);
    wait_flag(0);
    rd(ad(2'd3, 2), d);
    chk("R7 new value", d[8 +: PW], 3'd3);

    // R9 freeze enabled
    for (int i = 0; i < QD; i++) wr(ad(2'd2, i), 16'h0007);
    wr(ad(2'd3, 1), 16'h0200);
    clear_flags();
    @(negedge clk); rises = 0;
    wr(ad(2'd3, 0), 16'h0009);
    wait_rises(4);
    freeze = 1'b1;
    repeat (100) @(negedge clk);
    rd(ad(2'd3, 2), d);
    chk("R9 freeze halts", d[2], 1'b1);
    chk("R9 freeze boundary", rises, 8);
    freeze = 1'b0;
    wait_flag(0);
    chk("R9 resumed bits", rises, 24);

    // R9 freeze ignored when not enabled
    clear_flags();
    @(negedge clk); rises = 0;
    freeze = 1'b1;
    wr(ad(2'd3, 0), 16'h0001);
    wait_flag(0);
    rd(ad(2'd3, 2), d);
    chk("R9 freeze ignored", d[2], 1'b0);
    chk("R9 full run", rises, 24);
    freeze = 1'b0;

    // R10 slave select low while idle has no effect
    clear_flags();
    @(negedge clk); ss_n = 1'b0;
    repeat (20) @(negedge clk);
    ss_n = 1'b1;
    rd(ad(2'd3, 2), d);
    chk("R10 idle no fault", d[1], 1'b0);

    // R10 mode fault mid-transfer, R11 clear protocol, R12 fault irq
    wr(ad(2'd3, 1), 16'h0500);
    @(negedge clk); rises = 0;
    wr(ad(2'd3, 0), 16'h0021);
    wait_rises(4);
    ss_n = 1'b0;
    @(negedge clk);
    chk("R10 cs dropped", cs_n, 4'hF);
    chk("R10 sck low", sck, 1'b0);
    chk("R12 fault irq", irq, 1'b1);
    ss_n = 1'b1;
    rd(ad(2'd3, 0), d);
    chk("R10 run cleared", d[0], 1'b0);
    wr(ad(2'd3, 2), 16'h0000);
    rd(ad(2'd3, 2), d);
    chk("R11 not cleared without read", d[1], 1'b1);
    wr(ad(2'd3, 2), 16'h0000);
    rd(ad(2'd3, 2), d);
    chk("R11 cleared after read", d[1], 1'b0);
    chk("R12 irq low", irq, 1'b0);

    finish_run();
  end
endmodule